// File: doc/BRIEF.md
# Indirect Processor-Slot Hotplug Register Block

This block keeps the hotplug state of a fixed array of processor slots and exposes it to guest software through a small 12-byte register window. Software never addresses a slot directly. It first loads a 32-bit selector, and every status read, control write and data access then refers to the slot that the selector names. Each slot has three flags: enabled, insert-pending and remove-pending. The platform sets these flags through per-slot hot-add and hot-remove request inputs. Software clears them, or asks for an eject, which the block reports on an eject pulse output together with the slot index.

A command byte decides what the 32-bit data register does. Writing command 0 starts a hardware scan. The scan begins at the current selector, or at slot 0 when the selector is out of range, and visits the slots in ascending order with wrap-around, one slot per cycle. It moves the selector to the first slot that has a pending event. A data read under command 0 returns the selector. Commands 1 and 2 latch OS status-report (OST) event and status codes. Storing the status code also emits a one-cycle notification that carries both codes.

Top module: `hpslot_regblock`

## Requirements
- R1: After reset the selector is 0, the command is 0, all slot flags are clear, and busBusy, busRdValid, ejectPulse and ostValid are low.
- R2: A write to byte offset 0 loads all 32 bits of busWrData into the selector. With command 0, a read of byte offset 8 returns the selector.
- R3: A read request is answered by busRdValid exactly one cycle later, unless it is deferred under R7. A read of byte offset 4 returns {bit2 = remove-pending, bit1 = insert-pending AND enabled, bit0 = enabled}, and bits 31..3 are zero.
- R4: A one-cycle addReq[i] pulse sets slot i's enabled and insert-pending flags. A one-cycle remReq[i] pulse sets slot i's remove-pending flag. A request wins over a clear of the same flag in the same cycle.
- R5: A write to byte offset 4 acts on the selected slot. busWrData bit 1 clears insert-pending, bit 2 clears remove-pending, and bit 3 clears enabled and raises ejectPulse for one cycle, in the cycle after the write, with ejectSlot equal to the slot index. All other bits have no effect.
- R6: Writing 0 to byte offset 5 starts a scan, and busBusy is high for one cycle per visited slot. If the first slot with insert-pending or remove-pending set lies k steps after the start slot, busBusy lasts k+1 cycles and the selector becomes that slot. If no slot has a pending event, busBusy lasts NSLOTS cycles and the selector is unchanged.
- R7: While busBusy is high, all writes are ignored. A data read (offset 8) issued during a scan, or in the same cycle as the scan-starting write, is answered only after the scan has finished, and returns the updated selector.
- R8: A read of byte offset 8 returns 0xFFFFFFFF when the command is any value other than 0.
- R9: With command 1, a write to byte offset 8 stores ostEvent. With command 2, a write to offset 8 stores ostStatus and pulses ostValid for one cycle, in the cycle after the write, with both codes on the outputs. A data write under command 0 has no effect.
- R10: When the selector is NSLOTS or greater, status reads return 0 and control writes change no flag and raise no eject. Reads of offsets other than 4 and 8 return 0, and writes to offsets other than 0, 4, 5 and 8 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Byte offset of the access |
| busWrEn | input | 1 | Write strobe, one cycle per access |
| busRdEn | input | 1 | Read strobe, one cycle per access |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid with busRdValid |
| busRdValid | output | 1 | Read response strobe |
| busBusy | output | 1 | Scan in progress |
| addReq | input | NSLOTS | Per-slot hot-add request pulses |
| remReq | input | NSLOTS | Per-slot hot-remove request pulses |
| ejectPulse | output | 1 | One-cycle eject notification |
| ejectSlot | output | IDXW | Index of the ejected slot |
| ostValid | output | 1 | One-cycle OST notification |
| ostEvent | output | 32 | Latched OST event code |
| ostStatus | output | 32 | Latched OST status code |

## Verification
The hardest situation to reach from the ports is a data read that lands while a scan is still walking the slots, and that must come back late with the updated selector rather than a stale one. The bench issues the read in the cycle right after the scan-starting write and places the only pending slot far from the start slot, so that the scan runs long. In a second scan it also writes the selector mid-scan, to show that the write is dropped. Scan length and result are checked against a bench model for many combinations of pending masks and start positions, including a start position beyond the slot range.

// File: rtl/hpslot_pkg.sv
package hpslot_pkg;
  localparam logic [3:0] OFF_SEL  = 4'h0;
  localparam logic [3:0] OFF_STAT = 4'h4;
  localparam logic [3:0] OFF_CMD  = 4'h5;
  localparam logic [3:0] OFF_DATA = 4'h8;

  localparam logic [7:0] CMD_SCAN  = 8'd0;
  localparam logic [7:0] CMD_OSTEV = 8'd1;
  localparam logic [7:0] CMD_OSTST = 8'd2;

  typedef struct packed {
    logic        selWr;
    logic        ctlWr;
    logic        ostEvWr;
    logic        ostStWr;
    logic        scanHit;
    logic [31:0] scanIdx;
    logic [31:0] wrData;
  } hpStrobe_t;
endpackage

// File: rtl/hpslot_datapath.sv
module hpslot_datapath
  import hpslot_pkg::*;
#(
  parameter int NSLOTS = 8,
  parameter int IDXW   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  hpStrobe_t         strb,
  input  logic [NSLOTS-1:0] addReq,
  input  logic [NSLOTS-1:0] remReq,
  output logic [31:0]       selector,
  output logic [7:0]        statusByte,
  output logic [NSLOTS-1:0] slotPend,
  output logic              ejectPulse,
  output logic [IDXW-1:0]   ejectSlot,
  output logic              ostValid,
  output logic [31:0]       ostEvent,
  output logic [31:0]       ostStatus
);
  logic [NSLOTS-1:0] slotEn, slotIns, slotRem, selMatch;
  logic              selInRange;
  logic [IDXW-1:0]   selIdx;

  assign selInRange = (selector < 32'(NSLOTS));
  assign selIdx     = selector[IDXW-1:0];

  for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
    assign selMatch[g] = (selector == 32'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotEn[g]  <= 1'b0;
        slotIns[g] <= 1'b0;
        slotRem[g] <= 1'b0;
      end else begin
        if (strb.ctlWr && selMatch[g]) begin
          if (strb.wrData[1]) slotIns[g] <= 1'b0;
          if (strb.wrData[2]) slotRem[g] <= 1'b0;
          if (strb.wrData[3]) slotEn[g]  <= 1'b0;
        end
        if (addReq[g]) begin
          slotEn[g]  <= 1'b1;
          slotIns[g] <= 1'b1;
        end
        if (remReq[g]) slotRem[g] <= 1'b1;
      end
    end

    // R4: a hot-add request always leaves the slot enabled with insert pending
    a_r4_add_sets: assert property (@(posedge clk) disable iff (!rstN)
      addReq[g] |=> (slotEn[g] && slotIns[g]));
  end

  assign slotPend = slotIns | slotRem;

  always_comb begin
    statusByte = 8'h00;
    if (selInRange)
      statusByte = {5'b0, slotRem[selIdx], slotIns[selIdx] & slotEn[selIdx], slotEn[selIdx]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selector   <= '0;
      ejectPulse <= 1'b0;
      ejectSlot  <= '0;
      ostValid   <= 1'b0;
      ostEvent   <= '0;
      ostStatus  <= '0;
    end else begin
      if (strb.selWr)        selector <= strb.wrData;
      else if (strb.scanHit) selector <= strb.scanIdx;
      ejectPulse <= strb.ctlWr && selInRange && strb.wrData[3];
      ejectSlot  <= selIdx;
      ostValid   <= strb.ostStWr;
      if (strb.ostEvWr) ostEvent  <= strb.wrData;
      if (strb.ostStWr) ostStatus <= strb.wrData;
    end
  end

  // R6: a scan hit leaves the selector on a slot that still has an event
  a_r6_hit_pending: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.scanHit) |-> (selector == $past(strb.scanIdx)) && slotPend[selIdx]);

  // R5: an eject pulse is only ever caused by a control write with bit 3
  a_r5_eject_source: assert property (@(posedge clk) disable iff (!rstN)
    ejectPulse |-> $past(strb.ctlWr && strb.wrData[3]));

  // R9: the OST notification carries the status code just stored
  a_r9_ost_source: assert property (@(posedge clk) disable iff (!rstN)
    ostValid |-> $past(strb.ostStWr) && (ostStatus == $past(strb.wrData)));
endmodule

// File: rtl/hpslot_ctrl.sv
module hpslot_ctrl
  import hpslot_pkg::*;
#(
  parameter int NSLOTS = 8,
  parameter int IDXW   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [31:0]       busWrData,
  input  logic [31:0]       selector,
  input  logic [7:0]        statusByte,
  input  logic [NSLOTS-1:0] slotPend,
  output hpStrobe_t         strb,
  output logic              busBusy,
  output logic              busRdValid,
  output logic [31:0]       busRdData
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NSLOTS - 1);
  localparam logic [IDXW:0]   LAST_CNT = (IDXW + 1)'(NSLOTS - 1);

  logic [7:0]      cmdReg;
  logic [IDXW-1:0] scanIdx;
  logic [IDXW:0]   scanCnt;
  logic            pendRead;
  logic            wrOk, startScan, dataRd, rdNow, scanDone;
  logic [IDXW-1:0] startIdx;
  logic [31:0]     dataVal, rdMux;

  assign wrOk      = busWrEn && !busBusy;
  assign startScan = wrOk && (busAddr == OFF_CMD) && (busWrData[7:0] == CMD_SCAN);
  assign dataRd    = busRdEn && (busAddr == OFF_DATA);
  assign rdNow     = busRdEn && !(dataRd && (busBusy || startScan));
  assign startIdx  = (selector < 32'(NSLOTS)) ? selector[IDXW-1:0] : '0;
  assign scanDone  = busBusy && (slotPend[scanIdx] || (scanCnt == LAST_CNT));

  always_comb begin
    strb         = '0;
    strb.wrData  = busWrData;
    strb.selWr   = wrOk && (busAddr == OFF_SEL);
    strb.ctlWr   = wrOk && (busAddr == OFF_STAT);
    strb.ostEvWr = wrOk && (busAddr == OFF_DATA) && (cmdReg == CMD_OSTEV);
    strb.ostStWr = wrOk && (busAddr == OFF_DATA) && (cmdReg == CMD_OSTST);
    strb.scanHit = busBusy && slotPend[scanIdx];
    strb.scanIdx = 32'(scanIdx);
  end

  assign dataVal = (cmdReg == CMD_SCAN) ? selector : 32'hFFFF_FFFF;

  always_comb begin
    case (busAddr)
      OFF_STAT: rdMux = {24'b0, statusByte};
      OFF_DATA: rdMux = dataVal;
      default:  rdMux = 32'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg     <= CMD_SCAN;
      busBusy    <= 1'b0;
      scanIdx    <= '0;
      scanCnt    <= '0;
      pendRead   <= 1'b0;
      busRdValid <= 1'b0;
      busRdData  <= '0;
    end else begin
      busRdValid <= 1'b0;
      if (wrOk && (busAddr == OFF_CMD)) cmdReg <= busWrData[7:0];
      if (startScan) begin
        busBusy <= 1'b1;
        scanIdx <= startIdx;
        scanCnt <= '0;
      end else if (busBusy) begin
        if (scanDone) busBusy <= 1'b0;
        scanIdx <= (scanIdx == LAST_IDX) ? '0 : scanIdx + 1'b1;
        scanCnt <= scanCnt + 1'b1;
      end
      if (busRdEn && !rdNow) pendRead <= 1'b1;
      if (pendRead && !busBusy) begin
        pendRead   <= 1'b0;
        busRdValid <= 1'b1;
        busRdData  <= dataVal;
      end else if (rdNow) begin
        busRdValid <= 1'b1;
        busRdData  <= rdMux;
      end
    end
  end

  // R6: the scan never visits more than NSLOTS slots
  a_r6_scan_bound: assert property (@(posedge clk) disable iff (!rstN)
    busBusy |-> (scanCnt < (IDXW + 1)'(NSLOTS)));

  // R7: during a scan only a hit may move the selector
  a_r7_sel_held: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busBusy) && !$past(strb.scanHit)) |-> $stable(selector));

  // R3: status replies never carry bits above bit 2
  a_r3_status_width: assert property (@(posedge clk) disable iff (!rstN)
    (busRdValid && $past(busRdEn && (busAddr == OFF_STAT) && !pendRead)) |-> (busRdData[31:3] == 29'b0));

  // R8: an unsupported command makes the data register read as all ones
  a_r8_unsupported: assert property (@(posedge clk) disable iff (!rstN)
    (busRdValid && $past(dataRd && rdNow && !pendRead && (cmdReg != CMD_SCAN))) |-> (busRdData == 32'hFFFF_FFFF));
endmodule

// File: rtl/hpslot_regblock.sv
module hpslot_regblock
  import hpslot_pkg::*;
#(
  parameter int NSLOTS = 8,
  localparam int IDXW = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              busRdValid,
  output logic              busBusy,
  input  logic [NSLOTS-1:0] addReq,
  input  logic [NSLOTS-1:0] remReq,
  output logic              ejectPulse,
  output logic [IDXW-1:0]   ejectSlot,
  output logic              ostValid,
  output logic [31:0]       ostEvent,
  output logic [31:0]       ostStatus
);
  hpStrobe_t         strb;
  logic [31:0]       selector;
  logic [7:0]        statusByte;
  logic [NSLOTS-1:0] slotPend;

  hpslot_ctrl #(.NSLOTS(NSLOTS), .IDXW(IDXW)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .selector(selector),
    .statusByte(statusByte), .slotPend(slotPend), .strb(strb),
    .busBusy(busBusy), .busRdValid(busRdValid), .busRdData(busRdData)
  );

  hpslot_datapath #(.NSLOTS(NSLOTS), .IDXW(IDXW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addReq(addReq), .remReq(remReq),
    .selector(selector), .statusByte(statusByte), .slotPend(slotPend),
    .ejectPulse(ejectPulse), .ejectSlot(ejectSlot), .ostValid(ostValid),
    .ostEvent(ostEvent), .ostStatus(ostStatus)
  );
endmodule

// File: tb/hpslot_regblock_bench.sv
module hpslot_regblock_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic busRdValid, busBusy;
  logic [NS-1:0] addReq = '0, remReq = '0;
  logic ejectPulse, ostValid;
  logic [2:0] ejectSlot;
  logic [31:0] ostEvent, ostStatus;

  int checks = 0, fails = 0;
  logic [NS-1:0] mEn = '0, mIns = '0, mRem = '0;
  logic sawEject, sawOst;
  logic [2:0] sawEjectSlot;
  logic [31:0] rdVal;
  logic rdDuringBusy;

  hpslot_regblock #(.NSLOTS(NS)) u_hpslot_regblock (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData), .busRdValid(busRdValid),
    .busBusy(busBusy), .addReq(addReq), .remReq(remReq), .ejectPulse(ejectPulse),
    .ejectSlot(ejectSlot), .ostValid(ostValid), .ostEvent(ostEvent), .ostStatus(ostStatus)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; addReq = '0; remReq = '0;
    sawEject = ejectPulse; sawEjectSlot = ejectSlot; sawOst = ostValid;
  endtask

  task automatic rdReg(input logic [3:0] a);
    busAddr = a; busRdEn = 1'b1; rdDuringBusy = 1'b0;
    @(negedge clk);
    busRdEn = 1'b0;
    rdVal = 32'hDEAD_BEEF;
    for (int i = 0; i < 50; i++) begin
      if (busRdValid) begin
        rdVal = busRdData;
        if (busBusy) rdDuringBusy = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic pulseReq(input logic [NS-1:0] a, input logic [NS-1:0] r);
    addReq = a; remReq = r;
    @(negedge clk);
    addReq = '0; remReq = '0;
    mEn |= a; mIns |= a; mRem |= r;
  endtask

  function automatic logic [31:0] expStat(input int s);
    return {29'b0, mRem[s], mIns[s] & mEn[s], mEn[s]};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busBusy && !busRdValid && !ejectPulse && !ostValid, "R1 idle outputs", 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    rdReg(4'h8); chk(rdVal == 0, "R1 selector zero", rdVal, 0);
    for (int s = 0; s < NS; s++) begin
      wrReg(4'h0, s); rdReg(4'h4);
      chk(rdVal == 0, "R1 flags clear", rdVal, 0);
    end

    // R2: selector holds all 32 bits
    wrReg(4'h0, 32'hA5C3_0F17); rdReg(4'h8);
    chk(rdVal == 32'hA5C3_0F17, "R2 selector width", rdVal, 32'hA5C3_0F17);

    // R4 R5 R3: sweep every control value on every slot
    for (int s = 0; s < NS; s++) begin
      wrReg(4'h0, s);
      for (int v = 0; v < 16; v++) begin
        pulseReq(NS'(1) << s, NS'(1) << s);
        rdReg(4'h4);
        chk(rdVal == expStat(s), "R4 request sets flags", rdVal, expStat(s));
        wrReg(4'h4, {24'hFFFFFF, 4'hF, 4'(v)} & 32'hFFFF_FFF0 | 32'(v) | 32'hF0);
        if (v[1]) mIns[s] = 1'b0;
        if (v[2]) mRem[s] = 1'b0;
        if (v[3]) mEn[s] = 1'b0;
        chk(sawEject == v[3], "R5 eject pulse", 32'(sawEject), 32'(v[3]));
        if (v[3]) chk(sawEjectSlot == 3'(s), "R5 eject slot", 32'(sawEjectSlot), s);
        rdReg(4'h4);
        chk(rdVal == expStat(s), "R5 control result", rdVal, expStat(s));
      end
    end

    // R4: request beats a clear in the same cycle
    wrReg(4'h0, 2);
    addReq = NS'(4); remReq = NS'(4);
    wrReg(4'h4, 32'hE);
    mEn[2] = 1'b1; mIns[2] = 1'b1; mRem[2] = 1'b1;
    rdReg(4'h4);
    chk(rdVal == 32'h7, "R4 request wins", rdVal, 32'h7);

    // R6: scan over masks and start points, including an out-of-range start
    for (int m = 0; m < 6; m++) begin
      for (int st = 0; st <= NS; st++) begin
        logic [NS-1:0] mask;
        int expSel, expCyc, base, cyc;
        case (m)
          0: mask = 8'h00; 1: mask = 8'h20; 2: mask = 8'h81;
          3: mask = 8'hFF; 4: mask = 8'h24; default: mask = 8'h40;
        endcase
        for (int s = 0; s < NS; s++) begin
          wrReg(4'h0, s); wrReg(4'h4, 32'h6);
        end
        mIns = '0; mRem = '0;
        pulseReq('0, mask);
        wrReg(4'h0, st);
        base = (st < NS) ? st : 0;
        expSel = st; expCyc = NS;
        for (int k = 0; k < NS; k++) begin
          if (mask[(base + k) % NS]) begin
            expSel = (base + k) % NS; expCyc = k + 1; break;
          end
        end
        wrReg(4'h5, 0);
        cyc = 0;
        while (busBusy && cyc < 40) begin cyc++; @(negedge clk); end
        chk(cyc == expCyc, "R6 scan length", cyc, expCyc);
        rdReg(4'h8);
        chk(rdVal == expSel, "R6 scan result", rdVal, expSel);
      end
    end

    // R7: data read issued during a scan is deferred and sees the new selector
    for (int s = 0; s < NS; s++) begin wrReg(4'h0, s); wrReg(4'h4, 32'h6); end
    mIns = '0; mRem = '0;
    pulseReq('0, 8'h40);
    wrReg(4'h0, 0); wrReg(4'h5, 0);
    rdReg(4'h8);
    chk(rdVal == 6, "R7 deferred read value", rdVal, 6);
    chk(!rdDuringBusy, "R7 reply after scan", 32'(rdDuringBusy), 0);
    // R7: selector write during a scan is dropped
    pulseReq('0, 8'h80); wrReg(4'h4, 32'h4);
    wrReg(4'h0, 0); wrReg(4'h5, 0);
    wrReg(4'h0, 3);
    while (busBusy) @(negedge clk);
    rdReg(4'h8);
    chk(rdVal == 7, "R7 write ignored while busy", rdVal, 7);

    // R9 R8: OST codes and unsupported commands
    wrReg(4'h5, 1); wrReg(4'h8, 32'h0000_0103);
    chk(!sawOst, "R9 no pulse on event store", 32'(sawOst), 0);
    rdReg(4'h8); chk(rdVal == 32'hFFFF_FFFF, "R8 cmd1 read", rdVal, 32'hFFFF_FFFF);
    wrReg(4'h5, 2); wrReg(4'h8, 32'h0000_0080);
    chk(sawOst && ostEvent == 32'h103 && ostStatus == 32'h80, "R9 ost notify", ostStatus, 32'h80);
    @(negedge clk); chk(!ostValid, "R9 one-cycle pulse", 32'(ostValid), 0);
    rdReg(4'h8); chk(rdVal == 32'hFFFF_FFFF, "R8 cmd2 read", rdVal, 32'hFFFF_FFFF);
    wrReg(4'h5, 3); rdReg(4'h8); chk(rdVal == 32'hFFFF_FFFF, "R8 cmd3 read", rdVal, 32'hFFFF_FFFF);
    wrReg(4'h5, 8'hFF); rdReg(4'h8); chk(rdVal == 32'hFFFF_FFFF, "R8 cmdFF read", rdVal, 32'hFFFF_FFFF);
    wrReg(4'h5, 0); while (busBusy) @(negedge clk);
    wrReg(4'h0, 5); wrReg(4'h8, 32'h1234);
    rdReg(4'h8); chk(rdVal == 5, "R9 cmd0 write ignored", rdVal, 5);

    // R10: out-of-range selector and undocumented offsets
    pulseReq(8'h01, 8'h00);
    wrReg(4'h0, 9); rdReg(4'h4); chk(rdVal == 0, "R10 status out of range", rdVal, 0);
    wrReg(4'h4, 32'hE); chk(!sawEject, "R10 no eject out of range", 32'(sawEject), 0);
    wrReg(4'h0, 32'hFFFF_FFFF); rdReg(4'h4); chk(rdVal == 0, "R10 status max sel", rdVal, 0);
    wrReg(4'h0, 0); rdReg(4'h4);
    chk(rdVal == expStat(0), "R10 slot0 untouched", rdVal, expStat(0));
    for (int a = 0; a < 16; a++) begin
      if (a != 4 && a != 8) begin
        rdReg(4'(a)); chk(rdVal == 0, "R10 other offset reads zero", rdVal, 0);
      end
    end
    wrReg(4'hC, 3); wrReg(4'h6, 32'hFF); rdReg(4'h8);
    chk(rdVal == 0, "R10 other offset write ignored", rdVal, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule